// File: doc/BRIEF.md
# SPI Transfer Buffer Flags and Request Generator

This block is the buffering stage between the software-visible registers of an SPI controller and its serial shift engine. It holds one eight-word, sixteen-bit queue for outgoing words and one for incoming words. It turns the fill levels of both queues into status flags. Each flag can be sent to a single interrupt line through its own enable. Four of the flags can also raise DMA request lines through separate enables.

Software writes outgoing words into the transmit queue, and the shift engine takes them from the head of that queue. The engine pushes received words into the receive queue, and a register read takes them out. There are two sticky error flags: receive overflow and bit-count overflow. Each flag is held by a two-state machine with the states `STK_CLEAR` and `STK_HELD`. The transition `STK_CLEAR -> STK_HELD` happens on the set event. The transition `STK_HELD -> STK_CLEAR` happens on a clearing write to the status register, but only if no set event occurs in the same cycle; a set event wins. All other cycles keep the current state.

Top module: `spi_buffer_flags`

## Requirements
- R1: After reset both queues are empty, all enables are zero, `irq` and `dma_req` are low, the status register reads 0x0003, the fill register reads 0x0000 and the DMA register reads 0x00C0.
- R2: Words written to register offset 1 are presented on `eng_tx_data` in write order. `eng_tx_valid` is high while the transmit queue is not empty, and each `eng_tx_pop` with a word present removes one word. A pop while the queue is empty has no effect.
- R3: A write to offset 1 while the transmit queue holds 8 words is ignored: the fill count stays at 8 and the queued words are unchanged.
- R4: Reading offset 0 returns the oldest received word and removes it. Reading offset 0 while the receive queue is empty returns 0. Status bit 3 (receive data ready) is 1 while at least one word is held.
- R5: The status register reports these flags. Bit 0 is set when the transmit queue is empty. Bit 1 is set when it holds 4 or fewer words. Bit 2 is set when it holds 8 words. Bit 4 is set when the receive queue holds 4 or more words. Bit 5 is set when it holds 8 words.
- R6: If the engine pushes while the receive queue holds 8 words, the incoming word is discarded and status bit 6 is set. Bit 6 stays set until it is cleared by a write.
- R7: A one-cycle pulse on `eng_bitcnt_ovf` sets status bit 7. Bit 7 stays set until it is cleared by a write.
- R8: A write to offset 2 loads the interrupt enables from bits 15:8. The same write clears sticky bit 6 if written bit 6 is 0, and clears sticky bit 7 if written bit 7 is 0. Writing 0 therefore clears both sticky flags and all enables. Reading offset 2 returns {enables, status}.
- R9: `irq` is high exactly when some status bit k (0..7) and enable bit k+8 are both 1.
- R10: The fill register at offset 3 reads the transmit count in bits 3:0 and the receive count in bits 7:4. All other bits read 0.
- R11: The DMA register at offset 4 reads these flags: receive half in bit 4, receive full in bit 5, transmit empty in bit 6 and transmit half in bit 7. It reads the request enables in bits 15:12, which are written from the same bits. `dma_req[i]` equals flag bit (4+i) ANDed with enable bit (12+i).
- R12: Offsets 5 to 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on offset 0) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| eng_rx_push | input | 1 | Engine pushes a received word |
| eng_rx_data | input | 16 | Received word |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | 16 | Head of transmit queue |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_bitcnt_ovf | input | 1 | Bit-count overflow event pulse |
| irq | output | 1 | Masked interrupt request |
| dma_req | output | 4 | DMA requests: rx half, rx full, tx empty, tx half |

## Verification
A wrong fill counter shows up at once, in the combinational status and fill readbacks. It also shows up in the flag thresholds one cycle after the push or pop that caused it. A corrupted queue pointer only shows when the affected word reaches the head, which can take up to eight transfers. For that reason the word order is checked through scoreboard queues across complete fill and drain cycles. A sticky-flag machine that drops out of `STK_HELD` shows as a missing status bit and interrupt on the next read.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned Q_DEPTH = 8;

    typedef enum logic [2:0] {
        A_RXDATA = 3'd0,
        A_TXDATA = 3'd1,
        A_STATUS = 3'd2,
        A_FILL   = 3'd3,
        A_DMA    = 3'd4
    } reg_addr_e;

    localparam int unsigned ST_TE = 0;
    localparam int unsigned ST_TH = 1;
    localparam int unsigned ST_TF = 2;
    localparam int unsigned ST_RR = 3;
    localparam int unsigned ST_RH = 4;
    localparam int unsigned ST_RF = 5;
    localparam int unsigned ST_RO = 6;
    localparam int unsigned ST_BO = 7;

    typedef enum logic {
        STK_CLEAR = 1'b0,
        STK_HELD  = 1'b1
    } sticky_state_e;
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign push_ok = push && (count != CW'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sfq_sticky.sv
module sfq_sticky
    import sfq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    sticky_state_e state_q;
    sticky_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STK_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STK_CLEAR: if (set_evt) state_d = STK_HELD;
            STK_HELD:  if (clr_req && !set_evt) state_d = STK_CLEAR;
            default:   state_d = STK_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == STK_HELD);
    end
endmodule

// File: rtl/sfq_req_map.sv
module sfq_req_map
    import sfq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned HALF = DEPTH / 2
) (
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    input  logic          rx_ovf,
    input  logic          bit_ovf,
    input  logic [7:0]    irq_en,
    input  logic [3:0]    dma_en,
    output logic [7:0]    status,
    output logic [3:0]    dma_flags,
    output logic          irq,
    output logic [3:0]    dma_req
);
    always_comb begin
        status        = '0;
        status[ST_TE] = (tx_cnt == '0);
        status[ST_TH] = (tx_cnt <= CW'(HALF));
        status[ST_TF] = (tx_cnt == CW'(DEPTH));
        status[ST_RR] = (rx_cnt != '0);
        status[ST_RH] = (rx_cnt >= CW'(HALF));
        status[ST_RF] = (rx_cnt == CW'(DEPTH));
        status[ST_RO] = rx_ovf;
        status[ST_BO] = bit_ovf;
    end

    assign dma_flags = {status[ST_TH], status[ST_TE], status[ST_RF], status[ST_RH]};
    assign irq       = |(status & irq_en);
    assign dma_req   = dma_flags & dma_en;
endmodule

// File: rtl/spi_buffer_flags.sv
module spi_buffer_flags
    import sfq_pkg::*;
#(
    parameter int unsigned DEPTH = Q_DEPTH,
    parameter int unsigned WIDTH = WORD_W,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic             eng_rx_push,
    input  logic [WIDTH-1:0] eng_rx_data,
    input  logic             eng_tx_pop,
    output logic [WIDTH-1:0] eng_tx_data,
    output logic             eng_tx_valid,
    input  logic             eng_bitcnt_ovf,
    output logic             irq,
    output logic [3:0]       dma_req
);
    logic [CW-1:0]    tx_cnt;
    logic [CW-1:0]    rx_cnt;
    logic [WIDTH-1:0] rx_head;
    logic [7:0]       irq_en_q;
    logic [3:0]       dma_en_q;
    logic [7:0]       status_w;
    logic [3:0]       dma_flags_w;
    logic             rx_ovf;
    logic             bit_ovf;
    logic             tx_wr;
    logic             rx_rd;
    logic             stat_wr;
    logic             dma_wr;
    logic             ro_set;

    assign tx_wr   = reg_wr && (reg_addr == A_TXDATA);
    assign rx_rd   = reg_rd && (reg_addr == A_RXDATA);
    assign stat_wr = reg_wr && (reg_addr == A_STATUS);
    assign dma_wr  = reg_wr && (reg_addr == A_DMA);
    assign ro_set  = eng_rx_push && (rx_cnt == CW'(DEPTH));

    sfq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_wr),
        .push_data (reg_wdata[WIDTH-1:0]),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .count     (tx_cnt)
    );

    sfq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_rd),
        .head      (rx_head),
        .count     (rx_cnt)
    );

    sfq_sticky u_ro (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (ro_set),
        .clr_req (stat_wr && !reg_wdata[ST_RO]),
        .flag    (rx_ovf)
    );

    sfq_sticky u_bo (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (eng_bitcnt_ovf),
        .clr_req (stat_wr && !reg_wdata[ST_BO]),
        .flag    (bit_ovf)
    );

    sfq_req_map #(.DEPTH(DEPTH)) u_map (
        .tx_cnt    (tx_cnt),
        .rx_cnt    (rx_cnt),
        .rx_ovf    (rx_ovf),
        .bit_ovf   (bit_ovf),
        .irq_en    (irq_en_q),
        .dma_en    (dma_en_q),
        .status    (status_w),
        .dma_flags (dma_flags_w),
        .irq       (irq),
        .dma_req   (dma_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q <= '0;
            dma_en_q <= '0;
        end else begin
            if (stat_wr) irq_en_q <= reg_wdata[15:8];
            if (dma_wr)  dma_en_q <= reg_wdata[15:12];
        end
    end

    assign eng_tx_valid = (tx_cnt != '0);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_RXDATA: if (rx_cnt != '0) reg_rdata = 16'(rx_head);
            A_STATUS: reg_rdata = {irq_en_q, status_w};
            A_FILL:   reg_rdata = {8'h00, 4'(rx_cnt), 4'(tx_cnt)};
            A_DMA:    reg_rdata = {dma_en_q, 4'h0, dma_flags_w, 4'h0};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sfq_checker.sv
module sfq_checker #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [15:0]   reg_wdata,
    input logic          eng_rx_push,
    input logic          eng_tx_pop,
    input logic [15:0]   eng_tx_data,
    input logic          eng_bitcnt_ovf,
    input logic          irq,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [7:0]    status,
    input logic [7:0]    irq_en
);
    logic tx_wr_c;
    logic rx_rd_c;
    logic ro_clr_c;
    assign tx_wr_c  = reg_wr && (reg_addr == 3'd1);
    assign rx_rd_c  = reg_rd && (reg_addr == 3'd0);
    assign ro_clr_c = reg_wr && (reg_addr == 3'd2) && !reg_wdata[6];

    p_tx_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == CW'(DEPTH) && tx_wr_c && !eng_tx_pop) |=> (tx_cnt == CW'(DEPTH) && $stable(eng_tx_data)));

    p_rx_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_c && rx_cnt != '0 && !eng_rx_push) |=> (rx_cnt == $past(rx_cnt) - 1'b1));

    p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == CW'(DEPTH) && eng_rx_push && !rx_rd_c) |=> (status[6] && rx_cnt == CW'(DEPTH)));

    p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !ro_clr_c) |=> status[6]);

    p_bo_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_bitcnt_ovf |=> status[7]);

    p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 8'h00) |-> !irq);
endmodule

bind spi_buffer_flags sfq_checker #(.DEPTH(DEPTH)) u_sfq_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_addr       (reg_addr),
    .reg_wr         (reg_wr),
    .reg_rd         (reg_rd),
    .reg_wdata      (reg_wdata),
    .eng_rx_push    (eng_rx_push),
    .eng_tx_pop     (eng_tx_pop),
    .eng_tx_data    (eng_tx_data),
    .eng_bitcnt_ovf (eng_bitcnt_ovf),
    .irq            (irq),
    .tx_cnt         (tx_cnt),
    .rx_cnt         (rx_cnt),
    .status         (status_w),
    .irq_en         (irq_en_q)
);

// File: tb/test_spi_buffer_flags.sv
module test_spi_buffer_flags;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        eng_rx_push = 1'b0;
    logic [15:0] eng_rx_data = '0;
    logic        eng_tx_pop = 1'b0;
    logic [15:0] eng_tx_data;
    logic        eng_tx_valid;
    logic        eng_bitcnt_ovf = 1'b0;
    logic        irq;
    logic [3:0]  dma_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] txq[$];
    logic [15:0] rxq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_buffer_flags i_spi_buffer_flags (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_tx_valid(eng_tx_valid), .eng_bitcnt_ovf(eng_bitcnt_ovf), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d, input bit accept);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        if (a == 3'd1 && accept) txq.push_back(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [15:0] exp, input string req);
        logic [15:0] v;
        reg_read(a, v);
        chk(v == exp, req, v, exp);
    endtask

    task automatic eng_push(input logic [15:0] d, input bit accept);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = d;
        if (accept) rxq.push_back(d);
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    // Monitor side of the transmit scoreboard: compare head word with queue front, then pop
    task automatic eng_pop();
        logic [15:0] e;
        @(negedge clk);
        if (txq.size() > 0) begin
            e = txq.pop_front();
            chk(eng_tx_valid && eng_tx_data == e, "R2 tx order", eng_tx_data, e);
        end else begin
            chk(!eng_tx_valid, "R2 empty valid", 16'(eng_tx_valid), 16'h0);
        end
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    // Monitor side of the receive scoreboard
    task automatic rx_drain_one();
        logic [15:0] v;
        logic [15:0] e;
        reg_read(3'd0, v);
        e = (rxq.size() > 0) ? rxq.pop_front() : 16'h0000;
        chk(v == e, "R4 rx order", v, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R11 DMA register layout
        chk(irq == 1'b0 && dma_req == 4'h0, "R1 outputs", {11'h0, irq, dma_req}, 16'h0);
        expect_reg(3'd2, 16'h0003, "R1 status");
        expect_reg(3'd3, 16'h0000, "R1 fill");
        expect_reg(3'd4, 16'h00C0, "R1 dma reg");

        // R2 / R3 / R5: fill the transmit queue
        for (int i = 0; i < 8; i++) reg_write(3'd1, 16'hA100 + 16'(i), 1'b1);
        expect_reg(3'd2, 16'h0004, "R5 tx full flags");
        reg_write(3'd1, 16'hDEAD, 1'b0);
        expect_reg(3'd3, 16'h0008, "R3 full write ignored");
        for (int i = 0; i < 4; i++) eng_pop();
        expect_reg(3'd2, 16'h0002, "R5 tx half at 4");
        for (int i = 0; i < 4; i++) eng_pop();
        expect_reg(3'd2, 16'h0003, "R5 tx empty");
        eng_pop();
        expect_reg(3'd3, 16'h0000, "R2 pop on empty");

        // R4 / R5 / R6 receive path
        for (int i = 0; i < 3; i++) eng_push(16'h5000 + 16'(i), 1'b1);
        expect_reg(3'd2, 16'h000B, "R4 ready below half");
        eng_push(16'h5003, 1'b1);
        expect_reg(3'd2, 16'h001B, "R5 rx half at 4");
        for (int i = 4; i < 8; i++) eng_push(16'h5000 + 16'(i), 1'b1);
        eng_push(16'hBEEF, 1'b0);
        expect_reg(3'd2, 16'h007B, "R6 overflow set, rx full");
        for (int i = 0; i < 8; i++) rx_drain_one();
        expect_reg(3'd2, 16'h0043, "R6 overflow sticky after drain");
        rx_drain_one();

        // R8 / R9 enables and clearing
        reg_write(3'd2, 16'h4040, 1'b0);
        expect_reg(3'd2, 16'h4043, "R8 enable write keeps sticky");
        chk(irq == 1'b1, "R9 irq on overflow", 16'(irq), 16'h1);
        reg_write(3'd2, 16'h0000, 1'b0);
        expect_reg(3'd2, 16'h0003, "R8 zero write clears");
        chk(irq == 1'b0, "R9 irq cleared", 16'(irq), 16'h0);

        // R7 bit-count overflow
        @(negedge clk); eng_bitcnt_ovf = 1'b1;
        @(negedge clk); eng_bitcnt_ovf = 1'b0;
        repeat (2) @(negedge clk);
        expect_reg(3'd2, 16'h0083, "R7 bitcount sticky");
        reg_write(3'd2, 16'h8080, 1'b0);
        chk(irq == 1'b1, "R9 irq on bitcount", 16'(irq), 16'h1);
        reg_write(3'd2, 16'h8000, 1'b0);
        expect_reg(3'd2, 16'h8003, "R8 bit7 zero clears");
        chk(irq == 1'b0, "R9 irq after clear", 16'(irq), 16'h0);
        reg_write(3'd2, 16'h0100, 1'b0);
        chk(irq == 1'b1, "R9 irq on tx empty", 16'(irq), 16'h1);
        reg_write(3'd2, 16'h0000, 1'b0);

        // R11 DMA requests
        reg_write(3'd4, 16'hF000, 1'b0);
        expect_reg(3'd4, 16'hF0C0, "R11 dma reg");
        chk(dma_req == 4'b1100, "R11 dma idle", 16'(dma_req), 16'h000C);
        for (int i = 0; i < 4; i++) eng_push(16'h6000 + 16'(i), 1'b1);
        expect_reg(3'd4, 16'hF0D0, "R11 dma rx half");
        chk(dma_req == 4'b1101, "R11 dma rx half req", 16'(dma_req), 16'h000D);

        // R10 fill register
        reg_write(3'd1, 16'h0A0A, 1'b1);
        reg_write(3'd1, 16'h0B0B, 1'b1);
        expect_reg(3'd3, 16'h0042, "R10 fill counts");
        chk(dma_req == 4'b1001, "R11 dma tx not empty", 16'(dma_req), 16'h0009);

        // R12 unused offsets
        reg_write(3'd7, 16'hFFFF, 1'b0);
        expect_reg(3'd7, 16'h0000, "R12 unused offset");
        expect_reg(3'd3, 16'h0042, "R12 write no effect");

        eng_pop();
        eng_pop();
        for (int i = 0; i < 4; i++) rx_drain_one();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0000 expected 0x0001");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule